// File: doc/BRIEF.md
# Barrel-Scheduled Peripheral Processor Core

This block runs ten small processor contexts on one shared execution datapath. Each context keeps its own 18-bit accumulator, 12-bit instruction address, a 3-bit phase counter and a private word memory. A slot counter picks exactly one context per clock, in fixed order 0 through 9, and then wraps around. In its slot, a context moves its current instruction forward by one phase. The phase counter is what lets an instruction spread over several turns. The program running in a context cannot read its phase counter. A debug port shows the phase counter, and the same port shows the accumulator and the instruction address of any one selected context.

Contexts share twelve 12-bit channel registers. Each register is either filled by the external side and drained by a context, or filled by a context and drained by the external side. One block-transfer instruction moves a run of words between a channel and context memory, one word per turn, which is one word every ten clocks. The accumulator holds the word count. When a context finds its channel not ready, it holds its state and tries again on its next turn.

Memories are loaded through a load port while `run` is low. The supported instruction subset is load, add, store, load-constant, jump, block-input and block-output. Every other opcode acts as a no-op.

Top module: `pp_barrel_core`

## Requirements
- R1: While `run` is high, `cur_ctx` steps 0,1,…,9,0 one step per clock, and only the context shown there changes state at that edge. While `run` is low, `cur_ctx` and all context state hold.
- R2: After reset, `cur_ctx` is 0. Every context has accumulator 0, instruction address 0 and phase 0. All channel registers are empty and hold data 0.
- R3: The phase encoding is 0 for decode, 1 for execute and 2 for block. A decode turn changes nothing except the phase. It moves to phase 2 for opcodes 6 and 7 and to phase 1 for every other opcode. An execute turn ends the instruction: the phase goes back to 0 and the address goes up by 1 (modulo 4096), except for a jump.
- R4: The opcode sits in bits 11:8 of the instruction word and the operand in bits 7:0. Opcode 2 adds the memory word at the operand address to the accumulator, modulo 2^18. Opcode 4 jumps to the zero-extended operand. Opcode 5 loads the zero-extended operand into the accumulator. Opcodes 0 and 8–15 do nothing.
- R5: Opcode 1 loads the accumulator from the zero-extended memory word at the operand address. Opcode 3 stores the low 12 accumulator bits there. Each context's memory is private and indexed by the low MEM_AW address bits. A load-port write while `run` is low changes only memory.
- R6: Opcodes 6 (channel to memory) and 7 (memory to channel) name the channel in bits 7:4. The word that follows the instruction is a buffer pointer. On each phase-2 turn, a zero accumulator ends the instruction with the address advanced by 2. Otherwise one word moves at the pointer, the pointer word goes up by 1 and the accumulator goes down by 1. If the pointer word and the buffer word are the same location, the pointer update wins.
- R7: A block input stalls when its channel is empty or the external side reads that channel in the same cycle. A block output stalls when its channel is full or the external side writes it in the same cycle. A channel index of 12 or more always stalls. A stalled turn changes no state.
- R8: An external write to an empty channel fills it with `ext_wdata`. An external write to a full channel is ignored and leaves the data unchanged. An external read of a full channel empties it. `ch_full` and `ch_data` show every register.
- R9: `dbg_acc`, `dbg_pc` and `dbg_phase` show the state of the context chosen by `dbg_sel` within the same cycle. They read 0 for a selection of 10 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables context execution and slot rotation |
| ld_we | input | 1 | Memory load strobe |
| ld_ctx | input | 4 | Context whose memory is loaded |
| ld_addr | input | MEM_AW (6) | Load word index |
| ld_data | input | 12 | Load word |
| ext_wr | input | 12 | Per-channel external write request |
| ext_wdata | input | 144 | Per-channel external write data, channel k at bits 12k+11:12k |
| ext_rd | input | 12 | Per-channel external read (drain) request |
| ch_full | output | 12 | Per-channel full flag |
| ch_data | output | 144 | Per-channel register contents |
| cur_ctx | output | 4 | Context served at the coming edge |
| dbg_sel | input | 4 | Context shown on the debug outputs |
| dbg_acc | output | 18 | Selected accumulator |
| dbg_pc | output | 12 | Selected instruction address |
| dbg_phase | output | 3 | Selected phase counter |

## Verification
The assertions run on every cycle and check four things: slot rotation and its hold while `run` is low, that the debug view stays frozen while execution is paused, that the phase counter keeps to its three legal values, and the channel register rules (data of a full register never moves, and a write to an empty register lands). Only the bench scenarios can show the instruction results. These are the accumulator arithmetic, memory loads and stores, pointer and count updates during block moves, stall behaviour when a channel is contested, and the private separation of the ten memories. To show them, the bench checks every turn against a behavioural model while the channel partners drive random traffic.

// File: rtl/pp_barrel_pkg.sv
package pp_barrel_pkg;
  localparam int unsigned WORD_W = 12;
  localparam int unsigned ACC_W  = 18;
  localparam int unsigned PC_W   = 12;
  localparam int unsigned PH_W   = 3;
  localparam int unsigned OPD_W  = 8;
  localparam int unsigned CHF_W  = 4;

  typedef enum logic [PH_W-1:0] {
    PH_DEC = 3'd0,
    PH_EXE = 3'd1,
    PH_BLK = 3'd2
  } phase_e;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_LDD  = 4'd1,
    OP_ADD  = 4'd2,
    OP_STD  = 4'd3,
    OP_JMP  = 4'd4,
    OP_LDC  = 4'd5,
    OP_BIN  = 4'd6,
    OP_BOUT = 4'd7
  } op_e;
endpackage

// File: rtl/pp_slot_ring.sv
module pp_slot_ring #(
  parameter int unsigned N = 10,
  localparam int unsigned SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          adv,
  output logic [SW-1:0] slot
);
  logic [SW-1:0] slot_q, slot_n;

  always_comb begin
    slot_n = slot_q;
    if (adv) slot_n = (slot_q == SW'(N - 1)) ? '0 : slot_q + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= slot_n;
  end

  assign slot = slot_q;
endmodule

// File: rtl/pp_ctx_mem.sv
module pp_ctx_mem #(
  parameter int unsigned NCTX = 10,
  parameter int unsigned AW   = 6,
  parameter int unsigned W    = 12,
  localparam int unsigned CW    = $clog2(NCTX),
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          ld_we,
  input  logic [CW-1:0] ld_ctx,
  input  logic [AW-1:0] ld_addr,
  input  logic [W-1:0]  ld_data,
  input  logic [CW-1:0] ctx,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic [AW-1:0] ra_c,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [W-1:0]  rd_c,
  input  logic          wr0_en,
  input  logic [AW-1:0] wr0_addr,
  input  logic [W-1:0]  wr0_data,
  input  logic          wr1_en,
  input  logic [AW-1:0] wr1_addr,
  input  logic [W-1:0]  wr1_data
);
  logic [W-1:0] mem [NCTX][DEPTH];
  logic         ld_ok, wr0_ok;

  assign ld_ok  = ld_we && (ld_ctx < CW'(NCTX));
  // pointer write (port 1) wins over data write on the same word
  assign wr0_ok = wr0_en && !(wr1_en && (wr1_addr == wr0_addr));

  always_ff @(posedge clk) begin
    if (ld_ok) begin
      mem[ld_ctx][ld_addr] <= ld_data;
    end else begin
      if (wr1_en) mem[ctx][wr1_addr] <= wr1_data;
      if (wr0_ok) mem[ctx][wr0_addr] <= wr0_data;
    end
  end

  assign rd_a = mem[ctx][ra_a];
  assign rd_b = mem[ctx][ra_b];
  assign rd_c = mem[ctx][ra_c];
endmodule

// File: rtl/pp_chan_bank.sv
module pp_chan_bank #(
  parameter int unsigned NCH = 12,
  parameter int unsigned W   = 12
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic [NCH-1:0]         ext_wr,
  input  logic [NCH-1:0][W-1:0]  ext_wdata,
  input  logic [NCH-1:0]         ext_rd,
  input  logic [NCH-1:0]         ctx_take,
  input  logic [NCH-1:0]         ctx_put,
  input  logic [W-1:0]           put_word,
  output logic [NCH-1:0]         full,
  output logic [NCH-1:0][W-1:0]  data
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic         f_q, f_n;
    logic [W-1:0] d_q, d_n;

    always_comb begin
      f_n = f_q;
      d_n = d_q;
      if (f_q) begin
        if (ext_rd[k] || ctx_take[k]) f_n = 1'b0;
      end else if (ext_wr[k]) begin
        f_n = 1'b1;
        d_n = ext_wdata[k];
      end else if (ctx_put[k]) begin
        f_n = 1'b1;
        d_n = put_word;
      end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        f_q <= 1'b0;
        d_q <= '0;
      end else begin
        f_q <= f_n;
        d_q <= d_n;
      end
    end

    assign full[k] = f_q;
    assign data[k] = d_q;
  end
endmodule

// File: rtl/pp_barrel_core.sv
module pp_barrel_core
  import pp_barrel_pkg::*;
#(
  parameter int unsigned NCTX   = 10,
  parameter int unsigned NCH    = 12,
  parameter int unsigned MEM_AW = 6,
  localparam int unsigned CTX_W = $clog2(NCTX)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  ld_we,
  input  logic [CTX_W-1:0]      ld_ctx,
  input  logic [MEM_AW-1:0]     ld_addr,
  input  logic [WORD_W-1:0]     ld_data,
  input  logic [NCH-1:0]        ext_wr,
  input  logic [NCH*WORD_W-1:0] ext_wdata,
  input  logic [NCH-1:0]        ext_rd,
  output logic [NCH-1:0]        ch_full,
  output logic [NCH*WORD_W-1:0] ch_data,
  output logic [CTX_W-1:0]      cur_ctx,
  input  logic [CTX_W-1:0]      dbg_sel,
  output logic [ACC_W-1:0]      dbg_acc,
  output logic [PC_W-1:0]       dbg_pc,
  output logic [PH_W-1:0]       dbg_phase
);
  localparam logic [CHF_W-1:0] NCH_L = CHF_W'(NCH);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic [CTX_W-1:0] slot;
  pp_slot_ring #(.N(NCTX)) u_ring (
    .clk(clk), .rst_ni(rst_i), .adv(run), .slot(slot)
  );
  assign cur_ctx = slot;

  // per-context architectural and hidden state
  logic [ACC_W-1:0] acc_q [NCTX];
  logic [PC_W-1:0]  pc_q  [NCTX];
  phase_e           ph_q  [NCTX];

  logic [ACC_W-1:0] cur_acc, acc_n;
  logic [PC_W-1:0]  cur_pc, pc_n, pc_nx;
  phase_e           cur_ph, ph_n;
  assign cur_acc = acc_q[slot];
  assign cur_pc  = pc_q[slot];
  assign cur_ph  = ph_q[slot];
  assign pc_nx   = cur_pc + PC_W'(1);

  // memory and channel hookup
  logic [WORD_W-1:0] instr, ptr_w, opnd_w;
  logic [OPD_W-1:0]  opd;
  logic [CHF_W-1:0]  ch_i;
  op_e               op;
  logic [PC_W-1:0]   c_addr;
  logic              wr0_en, wr1_en;
  logic [PC_W-1:0]   wr0_addr;
  logic [WORD_W-1:0] wr0_data;
  logic [NCH-1:0]    take_v, put_v;
  logic [NCH-1:0][WORD_W-1:0] wd_a, chd_a;
  logic              ch_ok, in_rdy, out_rdy;

  assign op     = op_e'(instr[11:8]);
  assign opd    = instr[OPD_W-1:0];
  assign ch_i   = instr[7:4];
  assign c_addr = (cur_ph == PH_BLK) ? {ptr_w} : {{(PC_W-OPD_W){1'b0}}, opd};
  assign wd_a   = ext_wdata;
  assign ch_data = chd_a;

  assign ch_ok   = ch_i < NCH_L;
  assign in_rdy  = ch_ok && ch_full[ch_i] && !ext_rd[ch_i];
  assign out_rdy = ch_ok && !ch_full[ch_i] && !ext_wr[ch_i];

  pp_ctx_mem #(.NCTX(NCTX), .AW(MEM_AW), .W(WORD_W)) u_mem (
    .clk(clk),
    .ld_we(ld_we), .ld_ctx(ld_ctx), .ld_addr(ld_addr), .ld_data(ld_data),
    .ctx(slot),
    .ra_a(cur_pc[MEM_AW-1:0]), .ra_b(pc_nx[MEM_AW-1:0]), .ra_c(c_addr[MEM_AW-1:0]),
    .rd_a(instr), .rd_b(ptr_w), .rd_c(opnd_w),
    .wr0_en(wr0_en), .wr0_addr(wr0_addr[MEM_AW-1:0]), .wr0_data(wr0_data),
    .wr1_en(wr1_en), .wr1_addr(pc_nx[MEM_AW-1:0]), .wr1_data(ptr_w + WORD_W'(1))
  );

  pp_chan_bank #(.NCH(NCH), .W(WORD_W)) u_chan (
    .clk(clk), .rst_ni(rst_i),
    .ext_wr(ext_wr), .ext_wdata(wd_a), .ext_rd(ext_rd),
    .ctx_take(take_v), .ctx_put(put_v), .put_word(opnd_w),
    .full(ch_full), .data(chd_a)
  );

  // one phase step of the context in the current slot
  logic do_take, do_put, w0, w1;
  always_comb begin
    acc_n    = cur_acc;
    pc_n     = cur_pc;
    ph_n     = cur_ph;
    w0       = 1'b0;
    w1       = 1'b0;
    wr0_addr = c_addr;
    wr0_data = cur_acc[WORD_W-1:0];
    do_take  = 1'b0;
    do_put   = 1'b0;
    unique case (cur_ph)
      PH_DEC: ph_n = (op == OP_BIN || op == OP_BOUT) ? PH_BLK : PH_EXE;
      PH_EXE: begin
        ph_n = PH_DEC;
        pc_n = pc_nx;
        case (op)
          OP_LDD: acc_n = {{(ACC_W-WORD_W){1'b0}}, opnd_w};
          OP_ADD: acc_n = cur_acc + {{(ACC_W-WORD_W){1'b0}}, opnd_w};
          OP_STD: w0 = 1'b1;
          OP_JMP: pc_n = {{(PC_W-OPD_W){1'b0}}, opd};
          OP_LDC: acc_n = {{(ACC_W-OPD_W){1'b0}}, opd};
          default: ;
        endcase
      end
      PH_BLK: begin
        if (cur_acc == '0) begin
          pc_n = cur_pc + PC_W'(2);
          ph_n = PH_DEC;
        end else if (op == OP_BIN && in_rdy) begin
          w0       = 1'b1;
          wr0_data = chd_a[ch_i];
          w1       = 1'b1;
          do_take  = 1'b1;
          acc_n    = cur_acc - ACC_W'(1);
        end else if (op == OP_BOUT && out_rdy) begin
          w1     = 1'b1;
          do_put = 1'b1;
          acc_n  = cur_acc - ACC_W'(1);
        end
      end
      default: ph_n = PH_DEC;
    endcase
  end

  assign wr0_en = run && w0;
  assign wr1_en = run && w1;
  assign take_v = (run && do_take) ? (NCH'(1) << ch_i) : '0;
  assign put_v  = (run && do_put)  ? (NCH'(1) << ch_i) : '0;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      for (int i = 0; i < NCTX; i++) begin
        acc_q[i] <= '0;
        pc_q[i]  <= '0;
        ph_q[i]  <= PH_DEC;
      end
    end else if (run) begin
      acc_q[slot] <= acc_n;
      pc_q[slot]  <= pc_n;
      ph_q[slot]  <= ph_n;
    end
  end

  // debug view
  logic dbg_ok;
  assign dbg_ok    = dbg_sel < CTX_W'(NCTX);
  assign dbg_acc   = dbg_ok ? acc_q[dbg_sel] : '0;
  assign dbg_pc    = dbg_ok ? pc_q[dbg_sel]  : '0;
  assign dbg_phase = dbg_ok ? ph_q[dbg_sel]  : '0;
endmodule

// File: rtl/pp_barrel_core_chk.sv
module pp_barrel_core_chk #(
  parameter int unsigned NCTX = 10,
  parameter int unsigned NCH  = 12,
  parameter int unsigned W    = 12,
  localparam int unsigned CW  = $clog2(NCTX)
) (
  input logic           clk,
  input logic           rst_i,
  input logic           run,
  input logic [CW-1:0]  cur_ctx,
  input logic [CW-1:0]  dbg_sel,
  input logic [17:0]    dbg_acc,
  input logic [11:0]    dbg_pc,
  input logic [2:0]     dbg_phase,
  input logic [NCH-1:0] ext_wr,
  input logic [NCH*W-1:0] ext_wdata,
  input logic [NCH-1:0] ch_full,
  input logic [NCH*W-1:0] ch_data
);
  a_r1_rotate: assert property (@(posedge clk) disable iff (!rst_i)
    run |=> cur_ctx == (($past(cur_ctx) == CW'(NCTX - 1)) ? '0 : $past(cur_ctx) + CW'(1)));

  a_r1_hold_slot: assert property (@(posedge clk) disable iff (!rst_i)
    !run |=> $stable(cur_ctx));

  a_r1_hold_state: assert property (@(posedge clk) disable iff (!rst_i)
    !run |=> (dbg_sel != $past(dbg_sel)) ||
             ($stable(dbg_acc) && $stable(dbg_pc) && $stable(dbg_phase)));

  a_r3_phase_legal: assert property (@(posedge clk) disable iff (!rst_i)
    dbg_phase <= 3'd2);

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    a_r8_full_keeps_data: assert property (@(posedge clk) disable iff (!rst_i)
      ch_full[k] |=> $stable(ch_data[k*W +: W]));

    a_r8_empty_write_lands: assert property (@(posedge clk) disable iff (!rst_i)
      (!ch_full[k] && ext_wr[k]) |=>
        (ch_full[k] && ch_data[k*W +: W] == $past(ext_wdata[k*W +: W])));
  end
endmodule

bind pp_barrel_core pp_barrel_core_chk #(.NCTX(NCTX), .NCH(NCH), .W(pp_barrel_pkg::WORD_W)) u_chk (
  .clk(clk), .rst_i(rst_i), .run(run), .cur_ctx(cur_ctx), .dbg_sel(dbg_sel),
  .dbg_acc(dbg_acc), .dbg_pc(dbg_pc), .dbg_phase(dbg_phase),
  .ext_wr(ext_wr), .ext_wdata(ext_wdata), .ch_full(ch_full), .ch_data(ch_data)
);

// File: tb/pp_barrel_core_tb.sv
module pp_barrel_core_tb;
  localparam int NCTX = 10;
  localparam int NCH  = 12;
  localparam int W    = 12;
  localparam int MW   = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n, run, ld_we;
  logic [3:0]      ld_ctx;
  logic [5:0]      ld_addr;
  logic [11:0]     ld_data;
  logic [NCH-1:0]  ext_wr, ext_rd, ch_full;
  logic [NCH*W-1:0] ext_wdata, ch_data;
  logic [3:0]      cur_ctx, dbg_sel;
  logic [17:0]     dbg_acc;
  logic [11:0]     dbg_pc;
  logic [2:0]      dbg_phase;

  pp_barrel_core u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .ld_we(ld_we), .ld_ctx(ld_ctx),
    .ld_addr(ld_addr), .ld_data(ld_data), .ext_wr(ext_wr), .ext_wdata(ext_wdata),
    .ext_rd(ext_rd), .ch_full(ch_full), .ch_data(ch_data), .cur_ctx(cur_ctx),
    .dbg_sel(dbg_sel), .dbg_acc(dbg_acc), .dbg_pc(dbg_pc), .dbg_phase(dbg_phase)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // behavioural reference state
  int    m_mem [NCTX][MW];
  int    m_acc [NCTX];
  int    m_pc  [NCTX];
  int    m_ph  [NCTX];
  int    m_full[NCH];
  int    m_data[NCH];
  int    m_slot;
  bit    m_on = 1'b0;
  string m_tag = "R1";

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int prog(input int c, input int a);
    case (a)
      0:  return 'h500 | (3 + c);
      1:  return 'h600 | (c << 4);
      2:  return 'h020;
      3:  return 'h500 | (2 + c);
      4:  return 'h700 | ((10 + c % 2) << 4);
      5:  return 'h020;
      6:  return 'h121;
      7:  return 'h220;
      8:  return 'h330;
      9:  return 'h130;
      10: return 'h500;
      11: return 'h600 | (c << 4);
      12: return 'h028;
      13: return 'h520;
      14: return 'h302;
      15: return 'h305;
      16: return 'hF00;
      17: return 'h400;
      'h21: return 7 * c + 1;
      default: return 0;
    endcase
  endfunction

  task automatic m_step();
    int c, ins, op, opd, ch, ptr, pw;
    bit rdy;
    bit tk[NCH];
    bit pt[NCH];
    pw = 0;
    for (int k = 0; k < NCH; k++) begin tk[k] = 0; pt[k] = 0; end
    m_tag = "R1";
    if (run) begin
      c   = m_slot;
      ins = m_mem[c][m_pc[c] % MW];
      op  = ins >> 8;
      opd = ins & 255;
      ch  = (ins >> 4) & 15;
      if (m_ph[c] == 0) begin
        m_ph[c] = (op == 6 || op == 7) ? 2 : 1;
        m_tag = "R3";
      end else if (m_ph[c] == 1) begin
        m_tag = "R4";
        case (op)
          1: begin m_acc[c] = m_mem[c][opd % MW]; m_tag = "R5"; end
          2: m_acc[c] = (m_acc[c] + m_mem[c][opd % MW]) % (1 << 18);
          3: begin m_mem[c][opd % MW] = m_acc[c] % 4096; m_tag = "R5"; end
          5: m_acc[c] = opd;
          default: ;
        endcase
        m_pc[c] = (op == 4) ? opd : (m_pc[c] + 1) % 4096;
        m_ph[c] = 0;
      end else begin
        m_tag = "R6";
        if (m_acc[c] == 0) begin
          m_pc[c] = (m_pc[c] + 2) % 4096;
          m_ph[c] = 0;
        end else begin
          ptr = m_mem[c][(m_pc[c] + 1) % MW];
          rdy = 0;
          if (ch < NCH) begin
            if (op == 6) rdy = (m_full[ch] == 1) && !ext_rd[ch];
            else         rdy = (m_full[ch] == 0) && !ext_wr[ch];
          end
          if (!rdy) m_tag = "R7";
          else begin
            if (op == 6) begin m_mem[c][ptr % MW] = m_data[ch]; tk[ch] = 1; end
            else begin pw = m_mem[c][ptr % MW]; pt[ch] = 1; end
            m_mem[c][(m_pc[c] + 1) % MW] = (ptr + 1) % 4096;
            m_acc[c] = m_acc[c] - 1;
          end
        end
      end
      m_slot = (m_slot + 1) % NCTX;
    end
    for (int k = 0; k < NCH; k++) begin
      if (m_full[k] == 1) begin
        if (ext_rd[k] || tk[k]) m_full[k] = 0;
      end else if (ext_wr[k]) begin
        m_full[k] = 1;
        m_data[k] = int'(ext_wdata[k*W +: W]);
      end else if (pt[k]) begin
        m_full[k] = 1;
        m_data[k] = pw;
      end
    end
  endtask

  always @(posedge clk) if (m_on) m_step();

  task automatic compare_now();
    int s;
    logic [NCH-1:0] ef;
    logic [NCH*W-1:0] ed;
    s = int'(dbg_sel);
    chk("R1", "cur_ctx", cur_ctx, m_slot);
    chk(m_tag, "acc", dbg_acc, m_acc[s]);
    chk(m_tag, "pc", dbg_pc, m_pc[s]);
    chk("R3", "phase", dbg_phase, m_ph[s]);
    for (int k = 0; k < NCH; k++) begin
      ef[k] = m_full[k][0];
      ed[k*W +: W] = m_data[k][W-1:0];
    end
    chk("R8", "ch_full", ch_full, ef);
    chk("R8", "ch_data", ch_data, ed);
  endtask

  task automatic drive_traffic(input bit r);
    run = r;
    dbg_sel = 4'(m_slot);
    for (int k = 0; k < NCH; k++) begin
      if (k < 10) begin
        ext_wr[k] = ($urandom % 2) == 0;
        ext_rd[k] = ($urandom % 10) == 0;
      end else begin
        ext_wr[k] = ($urandom % 10) == 0;
        ext_rd[k] = ($urandom % 10) < 6;
      end
      ext_wdata[k*W +: W] = 12'($urandom % 4096);
    end
  endtask

  task automatic run_cycles(input int n, input bit r);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_now();
      drive_traffic(r);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; run = 0; ld_we = 0; ld_ctx = 0; ld_addr = 0; ld_data = 0;
    ext_wr = '0; ext_rd = '0; ext_wdata = '0; dbg_sel = 0;
    for (int c = 0; c < NCTX; c++) begin m_acc[c] = 0; m_pc[c] = 0; m_ph[c] = 0; end
    for (int k = 0; k < NCH; k++) begin m_full[k] = 0; m_data[k] = 0; end
    m_slot = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2: reset state of every context and channel
    for (int s = 0; s < NCTX; s++) begin
      dbg_sel = 4'(s);
      #1;
      chk("R2", "reset acc", dbg_acc, 0);
      chk("R2", "reset pc", dbg_pc, 0);
      chk("R2", "reset phase", dbg_phase, 0);
    end
    chk("R2", "reset cur_ctx", cur_ctx, 0);
    chk("R2", "reset ch_full", ch_full, 0);
    chk("R2", "reset ch_data", ch_data, 0);
    m_on = 1;

    // R5: load every context's private memory while run is low
    for (int c = 0; c < NCTX; c++) begin
      for (int a = 0; a < MW; a++) begin
        @(negedge clk);
        ld_we = 1; ld_ctx = 4'(c); ld_addr = 6'(a); ld_data = 12'(prog(c, a));
        m_mem[c][a] = prog(c, a);
      end
    end
    @(negedge clk);
    ld_we = 0;
    dbg_sel = 4'd3;
    #1;
    chk("R5", "load leaves acc", dbg_acc, 0);
    chk("R5", "load leaves pc", dbg_pc, 0);

    run_cycles(1500, 1'b1);
    run_cycles(40, 1'b0);

    // R9: debug view of every context at a paused point
    @(negedge clk);
    compare_now();
    run = 0; ext_wr = '0; ext_rd = '0;
    for (int s = 0; s < NCTX; s++) begin
      dbg_sel = 4'(s);
      #1;
      chk("R9", "dbg acc", dbg_acc, m_acc[s]);
      chk("R9", "dbg pc", dbg_pc, m_pc[s]);
      chk("R9", "dbg phase", dbg_phase, m_ph[s]);
    end
    dbg_sel = 4'd12;
    #1;
    chk("R9", "dbg out of range acc", dbg_acc, 0);
    chk("R9", "dbg out of range pc", dbg_pc, 0);
    dbg_sel = 4'(m_slot);

    run_cycles(2000, 1'b1);
    @(negedge clk);
    compare_now();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule